// File: doc/BRIEF.md
# Byte Register Guard with Sticky Soft Locks

This unit sits on a simple single-cycle bus in front of a small bank of byte-wide module registers. It gates every write to that bank. Each register byte has its own lock bit. A set lock bit turns later writes to that byte into rejected accesses, which pulse an error flag.

The address map has three windows. The direct window reaches the register bytes without side effects. The alias window reaches the same bytes. A write through the alias also arms that byte's lock, so software can write a value and freeze it in one access. The lock window holds one byte per group of four register bytes. Supervisor code can change individual lock bits there, but only bits whose paired write-enable is set in the same data byte.

The bank depth is a parameter. The window bases are parameters, and the lock count follows from the depth.

Top module: `regprot_unit`

## Requirements
- R1: A write to offset i, for i < REG_BYTES, stores the byte when i is unlocked. A read at offset i returns the stored byte with rd_valid high in the cycle after the request.
- R2: A read at ALIAS_BASE + i (default 0x2000 + i) returns the same byte as a direct read and changes no lock bit.
- R3: An accepted write at ALIAS_BASE + i stores the byte and sets the lock bit of byte i to 1.
- R4: The lock byte at LOCK_BASE + n (default 0x3800 + n) covers register bytes 4n to 4n+3. Lock bit k of lock byte n guards byte 4n+k.
- R5: A lock byte reads with bits 7:4 as zero and the lock bit of byte 4n+k at bit 3-k.
- R6: A supervisor write to a lock byte changes lock bit k to data bit 3-k only when data bit 7-k is 1. Otherwise that lock bit keeps its value.
- R7: A write, direct or alias, to a byte whose lock bit is 1 changes neither the byte nor any lock bit, and acc_err is high for exactly the next cycle.
- R8: A user-mode write (bus_super low) to a lock byte changes nothing and raises acc_err in the next cycle. User-mode reads of lock bytes are served normally.
- R9: Reset, synchronous and active high, clears every lock bit and drives rd_valid and acc_err low.
- R10: Reads never raise acc_err. An address outside the three windows reads as 0x00, and writes to such an address are dropped without an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_super | input | 1 | 1 = supervisor, 0 = user |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read result present, one cycle after a read request |
| acc_err | output | 1 | One-cycle pulse for a rejected write |

## Verification
On every cycle, the assertions check four things. rd_valid follows read requests by exactly one cycle. acc_err only follows a write, and a rejected write leaves the lock vector untouched. A lock bit falls only after a supervisor write into the lock window. They also check that lock reads return zero write-enable bits and that reset leaves every byte unlocked.

Only the bench scenarios can show the data path itself. These cover the mapping of lock bit k to byte 4n+k and the per-bit write-enable gating. They also cover a frozen byte keeping its old value, alias reads matching direct reads, and the top-of-bank and unmapped boundary cases.

// File: rtl/regprot_pkg.sv
package regprot_pkg;
  typedef enum logic [1:0] {
    RGN_NONE   = 2'd0,
    RGN_DIRECT = 2'd1,
    RGN_ALIAS  = 2'd2,
    RGN_LOCK   = 2'd3
  } region_e;
endpackage

// File: rtl/regprot_decode.sv
module regprot_decode
  import regprot_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int REG_BYTES  = 64,
  parameter int ALIAS_BASE = 'h2000,
  parameter int LOCK_BASE  = 'h3800,
  localparam int IDX_W     = $clog2(REG_BYTES),
  localparam int LOCKS     = REG_BYTES / 4,
  localparam int LK_W      = $clog2(LOCKS)
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           rgn,
  output logic [IDX_W-1:0]  byte_idx,
  output logic [LK_W-1:0]   lock_idx
);
  localparam logic [ADDR_W-1:0] DirEnd   = ADDR_W'(REG_BYTES);
  localparam logic [ADDR_W-1:0] AliasLo  = ADDR_W'(ALIAS_BASE);
  localparam logic [ADDR_W-1:0] AliasEnd = ADDR_W'(ALIAS_BASE + REG_BYTES);
  localparam logic [ADDR_W-1:0] LockLo   = ADDR_W'(LOCK_BASE);
  localparam logic [ADDR_W-1:0] LockEnd  = ADDR_W'(LOCK_BASE + LOCKS);

  always_comb begin
    rgn      = RGN_NONE;
    byte_idx = IDX_W'(addr);
    lock_idx = LK_W'(addr - LockLo);
    if (addr < DirEnd) begin
      rgn = RGN_DIRECT;
    end else if (addr >= AliasLo && addr < AliasEnd) begin
      rgn      = RGN_ALIAS;
      byte_idx = IDX_W'(addr - AliasLo);
    end else if (addr >= LockLo && addr < LockEnd) begin
      rgn = RGN_LOCK;
    end
  end
endmodule

// File: rtl/regprot_bank.sv
module regprot_bank #(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata
);
  logic [7:0] mem [DEPTH];

  // single port, read-first: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/regprot_locks.sv
module regprot_locks #(
  parameter int REG_BYTES = 64,
  localparam int IDX_W    = $clog2(REG_BYTES),
  localparam int LK_W     = $clog2(REG_BYTES / 4)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 set_en,
  input  logic [IDX_W-1:0]     set_idx,
  input  logic                 grp_we,
  input  logic [LK_W-1:0]      grp_idx,
  input  logic [7:0]           grp_wdata,
  output logic [3:0]           rd_nibble,
  output logic [REG_BYTES-1:0] lock_vec
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lock_vec <= '0;
    end else begin
      if (set_en) lock_vec[set_idx] <= 1'b1;
      if (grp_we) begin
        for (int k = 0; k < 4; k++) begin
          if (grp_wdata[7-k]) lock_vec[{grp_idx, 2'(k)}] <= grp_wdata[3-k];
        end
      end
    end
  end

  // lock of byte 4n+k appears at bit 3-k
  always_ff @(posedge clk) begin
    if (rst) rd_nibble <= '0;
    else rd_nibble <= {lock_vec[{grp_idx, 2'd0}], lock_vec[{grp_idx, 2'd1}],
                       lock_vec[{grp_idx, 2'd2}], lock_vec[{grp_idx, 2'd3}]};
  end
endmodule

// File: rtl/regprot_unit.sv
module regprot_unit
  import regprot_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int REG_BYTES  = 64,
  parameter int ALIAS_BASE = 'h2000,
  parameter int LOCK_BASE  = 'h3800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_super,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              acc_err
);
  localparam int IDX_W = $clog2(REG_BYTES);
  localparam int LK_W  = $clog2(REG_BYTES / 4);

  region_e              rgn, rgn_q;
  logic [IDX_W-1:0]     byte_idx;
  logic [LK_W-1:0]      lock_idx;
  logic [REG_BYTES-1:0] lock_vec;
  logic [7:0]           bank_q;
  logic [3:0]           lock_nib;
  logic                 wr, in_bank, byte_locked;
  logic                 bank_we, set_en, grp_we, err_d;

  regprot_decode #(
    .ADDR_W(ADDR_W), .REG_BYTES(REG_BYTES),
    .ALIAS_BASE(ALIAS_BASE), .LOCK_BASE(LOCK_BASE)
  ) u_dec (
    .addr(bus_addr), .rgn(rgn), .byte_idx(byte_idx), .lock_idx(lock_idx)
  );

  assign wr          = bus_valid & bus_write;
  assign in_bank     = (rgn == RGN_DIRECT) | (rgn == RGN_ALIAS);
  assign byte_locked = lock_vec[byte_idx];
  assign bank_we     = wr & in_bank & ~byte_locked;
  assign set_en      = bank_we & (rgn == RGN_ALIAS);
  assign grp_we      = wr & (rgn == RGN_LOCK) & bus_super;
  assign err_d       = wr & ((in_bank & byte_locked) | ((rgn == RGN_LOCK) & ~bus_super));

  regprot_bank #(.DEPTH(REG_BYTES)) u_bank (
    .clk(clk), .we(bank_we), .addr(byte_idx), .wdata(bus_wdata), .rdata(bank_q)
  );

  regprot_locks #(.REG_BYTES(REG_BYTES)) u_locks (
    .clk(clk), .rst(rst),
    .set_en(set_en), .set_idx(byte_idx),
    .grp_we(grp_we), .grp_idx(lock_idx), .grp_wdata(bus_wdata),
    .rd_nibble(lock_nib), .lock_vec(lock_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      acc_err  <= 1'b0;
      rgn_q    <= RGN_NONE;
    end else begin
      rd_valid <= bus_valid & ~bus_write;
      acc_err  <= err_d;
      rgn_q    <= rgn;
    end
  end

  always_comb begin
    case (rgn_q)
      RGN_DIRECT, RGN_ALIAS: rd_data = bank_q;
      RGN_LOCK:              rd_data = {4'b0000, lock_nib};
      default:               rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/regprot_checker.sv
module regprot_checker #(
  parameter int ADDR_W    = 14,
  parameter int REG_BYTES = 64,
  parameter int LOCK_BASE = 'h3800
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_valid,
  input logic                 bus_write,
  input logic                 bus_super,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [7:0]           rd_data,
  input logic                 rd_valid,
  input logic                 acc_err,
  input logic [REG_BYTES-1:0] lock_vec
);
  localparam logic [ADDR_W-1:0] LkLo  = ADDR_W'(LOCK_BASE);
  localparam logic [ADDR_W-1:0] LkEnd = ADDR_W'(LOCK_BASE + REG_BYTES / 4);

  logic in_lock;
  assign in_lock = (bus_addr >= LkLo) && (bus_addr < LkEnd);

  p_read_latency_r1: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (rd_valid == $past(bus_valid && !bus_write)));

  p_err_needs_write_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && acc_err) |-> $past(bus_valid && bus_write));

  p_reject_keeps_locks_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && acc_err) |-> (lock_vec == $past(lock_vec)));

  p_clear_needs_super_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && ((~lock_vec & $past(lock_vec)) != '0))
      |-> $past(bus_valid && bus_write && bus_super && in_lock));

  p_enables_read_zero_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && rd_valid && $past(in_lock)) |-> (rd_data[7:4] == 4'h0));

  p_reset_unlocks_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (lock_vec == '0 && !acc_err && !rd_valid));
endmodule

bind regprot_unit regprot_checker #(
  .ADDR_W(ADDR_W), .REG_BYTES(REG_BYTES), .LOCK_BASE(LOCK_BASE)
) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_super(bus_super), .bus_addr(bus_addr), .rd_data(rd_data),
  .rd_valid(rd_valid), .acc_err(acc_err), .lock_vec(lock_vec)
);

// File: tb/regprot_unit_test.sv
`timescale 1ns/1ps
module regprot_unit_test;
  localparam int ADDR_W = 14;
  localparam int NB     = 64;
  localparam int NL     = NB / 4;
  localparam int ABASE  = 'h2000;
  localparam int LBASE  = 'h3800;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_valid = 1'b0, bus_write = 1'b0, bus_super = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] rd_data;
  logic rd_valid, acc_err;

  regprot_unit #(.ADDR_W(ADDR_W), .REG_BYTES(NB), .ALIAS_BASE(ABASE), .LOCK_BASE(LBASE)) uut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_super(bus_super), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .acc_err(acc_err)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    bit         rv;
    logic [7:0] d;
    bit         err;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit mon_on = 0, done = 0;
  logic [7:0] m_mem [NB];
  bit         m_lk  [NB];

  // 0 none, 1 direct, 2 alias, 3 lock
  function automatic int kind_of(input int a, output int idx);
    idx = 0;
    if (a < NB) begin idx = a; return 1; end
    if (a >= ABASE && a < ABASE + NB) begin idx = a - ABASE; return 2; end
    if (a >= LBASE && a < LBASE + NL) begin idx = a - LBASE; return 3; end
    return 0;
  endfunction

  task automatic op(input bit wr, input int a, input logic [7:0] d, input bit sup, input string tag);
    exp_t e;
    int idx, kd;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = ADDR_W'(a); bus_wdata = d; bus_super = sup;
    kd = kind_of(a, idx);
    e.rv = !wr; e.d = 8'h00; e.err = 0; e.tag = tag;
    if (!wr) begin
      if (kd == 1 || kd == 2) e.d = m_mem[idx];
      else if (kd == 3) e.d = {4'b0, m_lk[4*idx], m_lk[4*idx+1], m_lk[4*idx+2], m_lk[4*idx+3]};
    end else begin
      if (kd == 1 || kd == 2) begin
        if (m_lk[idx]) e.err = 1;
        else begin
          m_mem[idx] = d;
          if (kd == 2) m_lk[idx] = 1;
        end
      end else if (kd == 3) begin
        if (!sup) e.err = 1;
        else for (int k = 0; k < 4; k++) if (d[7-k]) m_lk[4*idx+k] = d[3-k];
      end
    end
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
    end
  endtask

  // monitor: one expected item per request, compared after the edge that produced it
  always @(posedge clk) begin
    #1;
    if (mon_on) begin
      exp_t e;
      if (q.size() > 0) e = q.pop_front();
      else begin e.rv = 0; e.d = 8'h00; e.err = 0; e.tag = "R9 idle"; end
      checks++;
      if (rd_valid !== e.rv || acc_err !== e.err || (e.rv && rd_data !== e.d)) begin
        errors++;
        $display("FAIL %s: rv=%0b err=%0b data=%h expected rv=%0b err=%0b data=%h",
                 e.tag, rd_valid, acc_err, rd_data, e.rv, e.err, e.d);
      end
    end
  end

  initial begin
    for (int i = 0; i < NB; i++) begin m_mem[i] = 8'h00; m_lk[i] = 0; end
    repeat (4) @(negedge clk);
    checks++;
    if (rd_valid !== 1'b0 || acc_err !== 1'b0) begin
      errors++;
      $display("FAIL R9 in reset: rv=%0b err=%0b expected 0 0", rd_valid, acc_err);
    end
    rst = 1'b0;
    mon_on = 1;
    // R9: every lock starts clear
    op(0, LBASE, 0, 1, "R9 lock0 after reset");
    op(0, LBASE + NL - 1, 0, 0, "R9 last lock after reset");
    // R1: direct path
    op(1, 4, 8'h11, 0, "R1 wr4");
    op(1, 5, 8'hA5, 0, "R1 wr5");
    op(1, 6, 8'h22, 1, "R1 wr6");
    op(1, 7, 8'h33, 0, "R1 wr7");
    op(0, 5, 0, 0, "R1 rd5");
    // R2: alias read, no side effect
    op(0, ABASE + 5, 0, 0, "R2 alias rd5");
    op(0, LBASE + 1, 0, 1, "R2 locks unchanged");
    // R3/R4: alias write arms lock of byte 6 -> lock byte 1 bit 1
    op(1, ABASE + 6, 8'h3C, 0, "R3 alias wr6");
    op(0, 6, 0, 0, "R3 rd6");
    op(0, LBASE + 1, 0, 1, "R4 lock1 shows byte6");
    // R7: frozen byte
    op(1, 6, 8'hFF, 1, "R7 direct wr locked");
    op(1, ABASE + 6, 8'hEE, 1, "R7 alias wr locked");
    op(0, 6, 0, 0, "R7 byte6 kept");
    op(0, LBASE + 1, 0, 1, "R7 locks kept");
    // R6: write-enable gating
    op(1, LBASE + 1, 8'h0F, 1, "R6 no enables");
    op(0, LBASE + 1, 0, 1, "R6 unchanged");
    op(1, LBASE + 1, 8'h20, 1, "R6 clear slot2");
    op(0, LBASE + 1, 0, 1, "R6 cleared");
    op(1, 6, 8'h77, 0, "R6 wr6 unlocked");
    op(0, 6, 0, 0, "R6 rd6");
    // R4: slot 0 of lock byte 1 guards byte 4
    op(1, LBASE + 1, 8'h88, 1, "R4 set slot0");
    op(1, 4, 8'h55, 0, "R4 byte4 blocked");
    op(1, 5, 8'h66, 0, "R4 byte5 open");
    op(0, 4, 0, 0, "R4 byte4 kept");
    op(0, 5, 0, 0, "R4 byte5 new");
    op(0, LBASE + 1, 0, 0, "R4 lock1 slot0");
    // R8: user mode on lock bytes
    op(1, LBASE + 1, 8'hF0, 0, "R8 user wr lock");
    op(0, LBASE + 1, 0, 0, "R8 user rd lock");
    // R5: enables read as zero
    op(1, LBASE + 2, 8'hFF, 1, "R5 set all lock2");
    op(0, LBASE + 2, 0, 1, "R5 rd lock2");
    // R3 at the top of the bank: lock byte NL-1 slot 3 -> bit 0
    op(1, NB - 1, 8'h5A, 1, "R3 wr last");
    op(1, ABASE + NB - 1, 8'hA6, 1, "R3 alias wr last");
    op(0, LBASE + NL - 1, 0, 1, "R3 last lock");
    op(0, NB - 1, 0, 1, "R3 rd last");
    op(1, NB - 1, 8'h00, 1, "R7 last blocked");
    // R10: unmapped space
    op(0, 'h1000, 0, 1, "R10 unmapped rd");
    op(1, 'h1000, 8'hFF, 1, "R10 unmapped wr");
    op(0, LBASE + NL, 0, 1, "R10 past locks rd");
    op(1, LBASE + NL, 8'hFF, 0, "R10 past locks wr");
    idle(4);
    mon_on = 0;
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule